// File: doc/BRIEF.md
# Audio Converter Control Register Bank with Freeze

This block is the byte-wide register file that sits behind the control port of a stereo audio converter. A single synchronous port carries an address, write data and a write strobe in, and read data out. The file holds a fixed identification byte, a power register and a group of four configuration bytes. The configuration bytes drive the converter through a packed live-value bus. The power register drives three power-down lines: one for the ADC, one for the DAC and one for the whole device.

The power register also holds a freeze bit. While freeze is set, writes to the configuration group reach only a staging copy, and the live bus keeps its old value. When freeze is cleared, every staged byte moves to the live bus on the same clock edge. Software can therefore change several settings and have them take effect at once.

Read data is combinational from the address. Writes take effect on the rising clock edge on which the strobe is sampled high. The transport that frames these accesses over a serial bus is not part of this block.

Top module: `acodec_ctl_regs`

## Requirements
- R1: A synchronous reset (rst high on a clock edge) clears the power register, every staging byte and every live byte to 00h. After reset, all power-down outputs are 0, cfg_live is 0, and reads of 02h and 05h–08h return 00h.
- R2: Address 01h reads {4'b1100, REV}, where REV is the 4-bit revision parameter. Writes to 01h change nothing that is readable or output.
- R3: Address 02h keeps bit 7 (freeze), bit 5, bit 1 and bit 0 as written. Its bits 6, 4, 3 and 2 always read 0, whatever value is written.
- R4: pd_adc equals bit 5 of 02h, pd_dac equals bit 1 and pd_all equals bit 0. Each changes in the cycle after the write that sets or clears the bit.
- R5: With freeze at 0, a write to 05h+k (k = 0..3) updates byte k of cfg_live (bits 8k+7:8k) and the read-back of that address in the cycle after the write.
- R6: With freeze at 1, a write to 05h+k changes the read-back of that address to the new byte, while cfg_live stays unchanged.
- R7: A write to 02h with bit 7 at 0, made while freeze is 1, copies all four staged bytes onto cfg_live in the cycle after that write. All four bytes change together.
- R8: Setting bit 0 of 02h leaves every register readback and every cfg_live byte unchanged.
- R9: Reads of any address other than 01h, 02h and 05h–08h return 00h. Writes to those addresses have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| addr | input | 8 | Register address for reads and writes |
| wdata | input | 8 | Write data |
| wr_en | input | 1 | Write strobe, sampled on the clock edge |
| rdata | output | 8 | Read data for addr, combinational |
| cfg_live | output | 32 | Live configuration bytes; byte k belongs to address 05h+k |
| pd_adc | output | 1 | ADC power-down |
| pd_dac | output | 1 | DAC power-down |
| pd_all | output | 1 | Whole-device power-down |

## Verification
The assertions check, on every cycle:
- the identification value and the zero reserved bits at 02h;
- zero data at unmapped addresses;
- each power-down line against its read-back bit;
- that cfg_live stays stable while freeze holds and no release write occurs;
- that an open write reaches the live bus.

Only the bench's scenarios can show the following:
- that a release moves all four staged bytes at once, with the expected values;
- that the read-back shows staged data that differs from the live bus;
- that the device power-down bit and writes to unmapped addresses disturb nothing.

The bench shows these by comparing every address and the full live bus against a model after each write.

// File: rtl/acodec_ctl_regs.sv
module acodec_ctl_regs #(
  parameter logic [3:0] REV      = 4'h1,
  parameter int         GRP_BASE = 5,
  parameter int         GRP_N    = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [7:0]         addr,
  input  logic [7:0]         wdata,
  input  logic               wr_en,
  output logic [7:0]         rdata,
  output logic [GRP_N*8-1:0] cfg_live,
  output logic               pd_adc,
  output logic               pd_dac,
  output logic               pd_all
);
  localparam logic [7:0] A_ID     = 8'h01;
  localparam logic [7:0] A_PWR    = 8'h02;
  localparam logic [7:0] PWR_MASK = 8'hA3;
  localparam logic [7:0] ID_BYTE  = {4'b1100, REV};

  logic [7:0] pwr_q;
  logic [7:0] stage_q [GRP_N];
  logic       frz_q;
  logic       wr_pwr;
  logic       release_go;

  assign frz_q      = pwr_q[7];
  assign wr_pwr     = wr_en && (addr == A_PWR);
  assign release_go = wr_pwr && frz_q && !wdata[7];

  assign pd_adc = pwr_q[5];
  assign pd_dac = pwr_q[1];
  assign pd_all = pwr_q[0];

  always_ff @(posedge clk) begin
    if (rst)         pwr_q <= 8'h00;
    else if (wr_pwr) pwr_q <= wdata & PWR_MASK;
  end

  for (genvar g = 0; g < GRP_N; g++) begin : g_grp
    localparam logic [7:0] A_G = 8'(GRP_BASE + g);
    logic hit;
    assign hit = wr_en && (addr == A_G);

    always_ff @(posedge clk) begin
      if (rst)      stage_q[g] <= 8'h00;
      else if (hit) stage_q[g] <= wdata;
    end

    always_ff @(posedge clk) begin
      if (rst)                cfg_live[g*8 +: 8] <= 8'h00;
      else if (release_go)    cfg_live[g*8 +: 8] <= stage_q[g];
      else if (hit && !frz_q) cfg_live[g*8 +: 8] <= wdata;
    end
  end

  always_comb begin
    rdata = 8'h00;
    if (addr == A_ID)  rdata = ID_BYTE;
    if (addr == A_PWR) rdata = pwr_q;
    for (int i = 0; i < GRP_N; i++)
      if (addr == 8'(GRP_BASE + i)) rdata = stage_q[i];
  end
endmodule

// File: rtl/acodec_ctl_regs_chk.sv
module acodec_ctl_regs_chk #(
  parameter logic [3:0] REV      = 4'h1,
  parameter int         GRP_BASE = 5,
  parameter int         GRP_N    = 4
) (
  input logic               clk,
  input logic               rst,
  input logic [7:0]         addr,
  input logic [7:0]         wdata,
  input logic               wr_en,
  input logic [7:0]         rdata,
  input logic [GRP_N*8-1:0] cfg_live,
  input logic               pd_adc,
  input logic               pd_dac,
  input logic               pd_all,
  input logic               frz
);
  logic mapped;
  assign mapped = (addr == 8'h01) || (addr == 8'h02) ||
                  ((32'(addr) >= GRP_BASE) && (32'(addr) < GRP_BASE + GRP_N));

  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (cfg_live == '0) && !pd_adc && !pd_dac && !pd_all); // R1
  AST_ID_VALUE: assert property (@(posedge clk) disable iff (rst)
    (addr == 8'h01) |-> (rdata == {4'b1100, REV})); // R2
  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (rst)
    (addr == 8'h02) |-> ((rdata & 8'h5C) == 8'h00)); // R3
  AST_PD_BITS: assert property (@(posedge clk) disable iff (rst)
    (addr == 8'h02) |-> (pd_adc == rdata[5]) && (pd_dac == rdata[1]) && (pd_all == rdata[0])); // R4
  AST_OPEN_WRITE: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !frz && (32'(addr) == GRP_BASE)) |=> (cfg_live[7:0] == $past(wdata))); // R5
  AST_FROZEN_HOLD: assert property (@(posedge clk) disable iff (rst)
    (frz && !(wr_en && (addr == 8'h02) && !wdata[7])) |=> $stable(cfg_live)); // R6
  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (rst)
    !mapped |-> (rdata == 8'h00)); // R9
endmodule

bind acodec_ctl_regs acodec_ctl_regs_chk #(.REV(REV), .GRP_BASE(GRP_BASE), .GRP_N(GRP_N)) u_chk (
  .clk(clk), .rst(rst), .addr(addr), .wdata(wdata), .wr_en(wr_en), .rdata(rdata),
  .cfg_live(cfg_live), .pd_adc(pd_adc), .pd_dac(pd_dac), .pd_all(pd_all), .frz(frz_q)
);

// File: tb/acodec_ctl_regs_bench.sv
`timescale 1ns/1ps
module acodec_ctl_regs_bench;
  localparam logic [3:0] REV = 4'h1;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  addr = 8'h00;
  logic [7:0]  wdata = 8'h00;
  logic        wr_en = 1'b0;
  logic [7:0]  rdata;
  logic [31:0] cfg_live;
  logic        pd_adc, pd_dac, pd_all;

  int n_chk = 0;
  int n_bad = 0;

  logic [7:0] m_pwr;
  logic [7:0] m_stage [4];
  logic [7:0] m_live  [4];

  always #10 clk = ~clk;

  acodec_ctl_regs #(.REV(REV)) u_acodec_ctl_regs (
    .clk(clk), .rst(rst), .addr(addr), .wdata(wdata), .wr_en(wr_en), .rdata(rdata),
    .cfg_live(cfg_live), .pd_adc(pd_adc), .pd_dac(pd_dac), .pd_all(pd_all)
  );

  function automatic logic [7:0] m_read(input logic [7:0] a);
    if (a == 8'h01) return {4'b1100, REV};
    if (a == 8'h02) return m_pwr;
    if (a >= 8'h05 && a <= 8'h08) return m_stage[a - 8'h05];
    return 8'h00;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(posedge clk);
    if (a == 8'h02) begin
      if (m_pwr[7] && !d[7]) for (int k = 0; k < 4; k++) m_live[k] = m_stage[k];
      m_pwr = d & 8'hA3;
    end
    if (a >= 8'h05 && a <= 8'h08) begin
      m_stage[a - 8'h05] = d;
      if (!m_pwr[7]) m_live[a - 8'h05] = d;
    end
    #1 wr_en = 1'b0;
  endtask

  task automatic sweep(input string tag);
    for (int a = 0; a < 256; a++) begin
      addr = 8'(a);
      #1;
      if (rdata !== m_read(8'(a))) check({tag, " read"}, {24'h0, rdata}, {24'h0, m_read(8'(a))});
    end
    n_chk++;
    check({tag, " live"}, cfg_live, {m_live[3], m_live[2], m_live[1], m_live[0]});
    check({tag, " pd"}, {29'h0, pd_adc, pd_dac, pd_all}, {29'h0, m_pwr[5], m_pwr[1], m_pwr[0]});
  endtask

  initial begin
    #(20ns * 150000);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    m_pwr = 8'h00;
    for (int k = 0; k < 4; k++) begin m_stage[k] = 8'h00; m_live[k] = 8'h00; end
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    sweep("R1 reset R9 unmapped R2 id");

    wr(8'h01, 8'hFF);
    sweep("R2 id write ignored");

    for (int v = 0; v < 256; v++) begin
      wr(8'h02, 8'(v & 8'h7F));
      addr = 8'h02; #1;
      check("R3 power readback", {24'h0, rdata}, {24'h0, 8'(v & 8'h23)});
      check("R4 pd outputs", {29'h0, pd_adc, pd_dac, pd_all},
            {29'h0, 1'(v >> 5), 1'(v >> 1), 1'(v)});
    end
    wr(8'h02, 8'h00);

    for (int k = 0; k < 4; k++) wr(8'(5 + k), 8'(8'h11 * (k + 1)));
    sweep("R5 open writes");

    wr(8'h02, 8'h80);
    for (int k = 0; k < 4; k++) begin
      wr(8'(5 + k), 8'(8'hA0 + k));
      check("R6 live held", cfg_live, 32'h44332211);
    end
    sweep("R6 staged readback");

    wr(8'h02, 8'h00);
    check("R7 atomic release", cfg_live, 32'hA3A2A1A0);
    sweep("R7 after release");

    wr(8'h02, 8'h80);
    wr(8'h06, 8'h5A);
    wr(8'h02, 8'h80);
    check("R7 freeze rewrite holds", cfg_live, 32'hA3A2A1A0);
    wr(8'h02, 8'h00);
    check("R7 second release", cfg_live, 32'hA3A25AA0);

    wr(8'h02, 8'h01);
    sweep("R8 device power-down retains");
    check("R8 pd_all set", {31'h0, pd_all}, 32'h1);
    wr(8'h02, 8'h00);

    foreach (m_live[k]) begin end
    wr(8'h00, 8'hFF); wr(8'h03, 8'hFF); wr(8'h04, 8'hFF); wr(8'h09, 8'hFF); wr(8'hFF, 8'hFF);
    sweep("R9 unmapped writes");

    @(negedge clk); rst = 1'b1;
    @(posedge clk); #1 rst = 1'b0;
    m_pwr = 8'h00;
    for (int k = 0; k < 4; k++) begin m_stage[k] = 8'h00; m_live[k] = 8'h00; end
    sweep("R1 second reset");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule